// File: doc/BRIEF.md
# Write-Through Set-Associative Cache

This block sits between a processor's request port and a single-word memory bus. It holds 4 KB of data in 64 sets of four ways, with 16-byte lines. The top three address bits of each processor access pick its path. A zero prefix means the access may use the cache. The prefix `110` reaches on-chip scratch RAM when the half-size mode is on. Any other prefix passes straight to memory. Reads that miss fetch a whole line into the way that a 3-bit tree pseudo-LRU picks. Writes always go to memory, and they update the cache only when they hit.

A configuration input shrinks the cache to two ways per set. The two upper ways then serve as 2 KB of scratch RAM that the processor reads and writes with no bus traffic. A second requester port, meant for a DMA engine, shares the memory bus. It never looks up or changes the cache. A purge input clears every valid bit in a sweep of one set per cycle. Each requester holds its request, address and data steady until its ready output pulses for one cycle. The memory bus is driven the same way: `mem_req` stays high until `mem_ack` pulses.

Top module: `wtc_cache`

## Requirements
- R1: Once reset is released, no memory request is pending and no ready is given until a request arrives.
- R2: A processor read with address bits 31..29 equal to 000 that misses issues four memory reads of its 16-byte line, in the order byte offset 0, 4, 8, 12. The processor receives the requested word from the bus as that word arrives.
- R3: A cacheable read whose line is valid with a matching tag completes in the cycle it is presented, with no memory access, and returns the cached word.
- R4: A processor read with bits 31..29 not 000 (and not a scratch access) issues exactly one memory read at the unchanged address and leaves all tag, valid and replacement state unchanged.
- R5: Every processor write outside scratch RAM issues one memory write of its address and data. A write that hits also updates the cached word, so a later read returns it without a bus access.
- R6: A write miss does not allocate; a later read of that address misses.
- R7: Replacement uses three bits per set: bit 0 picks the victim pair (0: ways 0/1, 1: ways 2/3), bit 1 the way in pair 0/1, bit 2 the way in pair 2/3. A fill or read hit of a way sets these bits to point away from it. All bits start at zero.
- R8: A purge pulse clears all valid bits over 64 cycles. Requests presented meanwhile wait, and lines cached before the purge miss afterwards.
- R9: With the half-size mode on, lines live only in ways 0 and 1 (victim chosen by bit 1). Accesses with bits 31..29 equal to 110 read or write scratch RAM in one cycle without bus traffic, at way 2 + bit 10, set bits 9..4 and word bits 3..2. Line fills do not disturb it.
- R10: A DMA-port access issues one memory access at its address, whatever its top bits, and neither reads from nor changes the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_way | input | 1 | Half-size mode: two cache ways plus scratch RAM |
| purge | input | 1 | Pulse to invalidate every line |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Processor write when high |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, valid with cpu_ready |
| cpu_ready | output | 1 | Processor access complete |
| dma_req | input | 1 | DMA request, held until dma_ready |
| dma_we | input | 1 | DMA write when high |
| dma_addr | input | 32 | DMA byte address |
| dma_wdata | input | 32 | DMA write data |
| dma_rdata | output | 32 | DMA read data, valid with dma_ready |
| dma_ready | output | 1 | DMA access complete |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
The hardest state to reach is a chosen victim in a full set. That needs four fills, then a hit that reorders the tree, before the fifth tag arrives. The stimulus walks one untouched set through exactly that sequence. It then infers which way went by counting bus reads on later lookups. Stale data is told apart from fresh by changing the pattern the memory model returns between fills. This exposes whether a DMA read or an uncached read was served by the bus or by the cache.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PURGE,
    ST_FILL,
    ST_RDBYP,
    ST_WRITE,
    ST_DMA
  } wtc_state_e;

  // Victim from the 3-bit tree; half-size mode looks only at pair 0/1.
  function automatic logic [1:0] plru_victim(input logic [2:0] bits, input logic half);
    if (half || !bits[0]) return {1'b0, bits[1]};
    return {1'b1, bits[2]};
  endfunction

  // Point the tree away from the way just used.
  function automatic logic [2:0] plru_touch(input logic [2:0] bits, input logic [1:0] way);
    logic [2:0] nb;
    nb    = bits;
    nb[0] = ~way[1];
    if (way[1]) nb[2] = ~way[0];
    else        nb[1] = ~way[0];
    return nb;
  endfunction

endpackage

// File: rtl/wtc_tags.sv
module wtc_tags
  import wtc_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    two_way,
  input  logic [$clog2(SETS)-1:0] lk_set,
  input  logic [TAG_W-1:0]        lk_tag,
  output logic                    hit,
  output logic [1:0]              hit_way,
  output logic [1:0]              victim,
  input  logic                    touch_en,
  input  logic                    fill_en,
  input  logic [$clog2(SETS)-1:0] fill_set,
  input  logic [1:0]              fill_way,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic                    clr_en,
  input  logic [$clog2(SETS)-1:0] clr_set
);
  localparam int NWAYS = 4;

  logic [TAG_W-1:0] tag_q [SETS][NWAYS];
  logic [NWAYS-1:0] vld_q [SETS];
  logic [2:0]       lru_q [SETS];

  always_comb begin
    hit     = 1'b0;
    hit_way = 2'd0;
    for (int w = 0; w < NWAYS; w++) begin
      if (vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag) && (!two_way || w < 2)) begin
        hit     = 1'b1;
        hit_way = 2'(w);
      end
    end
  end

  assign victim = plru_victim(lru_q[lk_set], two_way);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= '0;
      end
    end else begin
      if (clr_en) vld_q[clr_set] <= '0;
      if (fill_en) begin
        vld_q[fill_set][fill_way] <= 1'b1;
        lru_q[fill_set]           <= plru_touch(lru_q[fill_set], fill_way);
      end
      if (touch_en) lru_q[lk_set] <= plru_touch(lru_q[lk_set], hit_way);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
  end

endmodule

// File: rtl/wtc_data.sv
module wtc_data #(
  parameter int DATA_W = 32,
  parameter int SETS   = 64,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic [1:0]               rd_way,
  input  logic [$clog2(SETS)-1:0]  rd_set,
  input  logic [$clog2(WORDS)-1:0] rd_word,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     wr_en,
  input  logic [1:0]               wr_way,
  input  logic [$clog2(SETS)-1:0]  wr_set,
  input  logic [$clog2(WORDS)-1:0] wr_word,
  input  logic [DATA_W-1:0]        wr_data
);
  localparam int NWAYS   = 4;
  localparam int ENTRIES = SETS * WORDS;

  logic [DATA_W-1:0] way_rd [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic [DATA_W-1:0] arr_q [ENTRIES];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 2'(w))) arr_q[{wr_set, wr_word}] <= wr_data;
    end
    assign way_rd[w] = arr_q[{rd_set, rd_word}];
  end

  assign rd_data = way_rd[rd_way];

endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 64,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              two_way,
  input  logic              purge,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              dma_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int WRD_W   = $clog2(WORDS);
  localparam int OFF_W   = WRD_W + 2;
  localparam int SET_W   = $clog2(SETS);
  localparam int SCR_BIT = OFF_W + SET_W;
  localparam int TAG_W   = ADDR_W - 3 - SCR_BIT;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // state registers and their next values
  wtc_state_e        state_q, state_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic [1:0]        way_q, way_n;
  logic              whit_q, whit_n;
  logic              dwe_q, dwe_n;
  logic              ppend_q, ppend_n;
  logic [WRD_W-1:0]  word_q, word_n;
  logic [SET_W-1:0]  pcnt_q, pcnt_n;

  // address decode of the incoming processor request
  logic [2:0]       c_region;
  logic             c_cacheable, c_scratch;
  logic [SET_W-1:0] c_set, q_set;
  logic [TAG_W-1:0] c_tag, q_tag;
  logic [WRD_W-1:0] c_word, q_word;

  assign c_region    = cpu_addr[ADDR_W-1 -: 3];
  assign c_cacheable = (c_region == 3'b000);
  assign c_scratch   = two_way && (c_region == 3'b110);
  assign c_set       = cpu_addr[OFF_W +: SET_W];
  assign c_tag       = cpu_addr[SCR_BIT +: TAG_W];
  assign c_word      = cpu_addr[2 +: WRD_W];
  assign q_set       = addr_q[OFF_W +: SET_W];
  assign q_tag       = addr_q[SCR_BIT +: TAG_W];
  assign q_word      = addr_q[2 +: WRD_W];

  // storage interfaces
  logic              hit, touch_en, fill_en, clr_en, dwr_en, purge_go;
  logic [1:0]        hit_way, victim, drd_way, dwr_way;
  logic [SET_W-1:0]  dwr_set;
  logic [WRD_W-1:0]  dwr_word;
  logic [DATA_W-1:0] dwr_data, drd_data;

  wtc_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .two_way  (two_way),
    .lk_set   (c_set),
    .lk_tag   (c_tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .victim   (victim),
    .touch_en (touch_en),
    .fill_en  (fill_en),
    .fill_set (q_set),
    .fill_way (way_q),
    .fill_tag (q_tag),
    .clr_en   (clr_en),
    .clr_set  (pcnt_q)
  );

  assign drd_way = c_scratch ? {1'b1, cpu_addr[SCR_BIT]} : hit_way;

  wtc_data #(.DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) u_data (
    .clk     (clk),
    .rd_way  (drd_way),
    .rd_set  (c_set),
    .rd_word (c_word),
    .rd_data (drd_data),
    .wr_en   (dwr_en),
    .wr_way  (dwr_way),
    .wr_set  (dwr_set),
    .wr_word (dwr_word),
    .wr_data (dwr_data)
  );

  assign purge_go = purge || ppend_q;

  // next-state logic
  always_comb begin
    state_n  = state_q;
    addr_n   = addr_q;
    wdata_n  = wdata_q;
    way_n    = way_q;
    whit_n   = whit_q;
    dwe_n    = dwe_q;
    word_n   = word_q;
    pcnt_n   = pcnt_q;
    ppend_n  = ppend_q || purge;
    touch_en = 1'b0;
    fill_en  = 1'b0;
    clr_en   = 1'b0;
    dwr_en   = 1'b0;
    dwr_way  = way_q;
    dwr_set  = q_set;
    dwr_word = word_q;
    dwr_data = mem_rdata;
    unique case (state_q)
      ST_IDLE: begin
        if (purge_go) begin
          state_n = ST_PURGE;
          pcnt_n  = '0;
          ppend_n = 1'b0;
        end else if (cpu_req) begin
          addr_n  = cpu_addr;
          wdata_n = cpu_wdata;
          if (c_scratch) begin
            dwr_en   = cpu_we;
            dwr_way  = {1'b1, cpu_addr[SCR_BIT]};
            dwr_set  = c_set;
            dwr_word = c_word;
            dwr_data = cpu_wdata;
          end else if (cpu_we) begin
            state_n = ST_WRITE;
            whit_n  = c_cacheable && hit;
            way_n   = hit_way;
          end else if (c_cacheable) begin
            if (hit) begin
              touch_en = 1'b1;
            end else begin
              state_n = ST_FILL;
              way_n   = victim;
              word_n  = '0;
            end
          end else begin
            state_n = ST_RDBYP;
          end
        end else if (dma_req) begin
          state_n = ST_DMA;
          addr_n  = dma_addr;
          wdata_n = dma_wdata;
          dwe_n   = dma_we;
        end
      end
      ST_PURGE: begin
        clr_en = 1'b1;
        if (pcnt_q == SET_W'(SETS - 1)) state_n = ST_IDLE;
        else                            pcnt_n  = pcnt_q + 1'b1;
      end
      ST_FILL: begin
        if (mem_ack) begin
          dwr_en = 1'b1;
          if (word_q == WRD_W'(WORDS - 1)) begin
            fill_en = 1'b1;
            state_n = ST_IDLE;
          end else begin
            word_n = word_q + 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          dwr_en   = whit_q;
          dwr_word = q_word;
          dwr_data = wdata_q;
          state_n  = ST_IDLE;
        end
      end
      ST_RDBYP, ST_DMA: begin
        if (mem_ack) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      way_q   <= '0;
      whit_q  <= 1'b0;
      dwe_q   <= 1'b0;
      ppend_q <= 1'b0;
      word_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      way_q   <= way_n;
      whit_q  <= whit_n;
      dwe_q   <= dwe_n;
      ppend_q <= ppend_n;
      word_q  <= word_n;
      pcnt_q  <= pcnt_n;
    end
  end

  // outputs
  logic idle_take;
  assign idle_take = (state_q == ST_IDLE) && cpu_req && !purge_go;

  assign cpu_ready = (idle_take && (c_scratch || (!cpu_we && c_cacheable && hit)))
                  || ((state_q == ST_FILL) && mem_ack && (word_q == q_word))
                  || (((state_q == ST_RDBYP) || (state_q == ST_WRITE)) && mem_ack);
  assign cpu_rdata = (state_q == ST_IDLE) ? drd_data : mem_rdata;

  assign dma_ready = (state_q == ST_DMA) && mem_ack;
  assign dma_rdata = mem_rdata;

  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_RDBYP)
                  || (state_q == ST_WRITE) || (state_q == ST_DMA);
  assign mem_we    = (state_q == ST_WRITE) || ((state_q == ST_DMA) && dwe_q);
  assign mem_addr  = (state_q == ST_FILL) ? {addr_q[ADDR_W-1:OFF_W], word_q, 2'b00} : addr_q;
  assign mem_wdata = wdata_q;

endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WRD_W  = 2,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n_s,
  input wtc_state_e        state_q,
  input logic [WRD_W-1:0]  word_q,
  input logic              two_way,
  input logic              cpu_ready,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fill_en,
  input logic              dwr_en,
  input logic              touch_en
);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n_s) |-> !mem_req);

  a_r2_fill_next_word: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_FILL && mem_ack && word_q != WRD_W'(WORDS - 1))
      |=> (mem_req && !mem_we && mem_addr == $past(mem_addr) + 32'd4));

  a_r4_bypass_single_read: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_RDBYP && mem_ack) |=> (state_q == ST_IDLE));

  a_r5_write_reaches_bus: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_ready && cpu_we && !(two_way && cpu_addr[ADDR_W-1 -: 3] == 3'b110))
      |-> (mem_req && mem_we && mem_ack));

  a_r8_purge_blocks: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_PURGE) |-> (!cpu_ready && !mem_req));

  a_r10_dma_leaves_cache: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_DMA) |-> (!fill_en && !dwr_en && !touch_en));

endmodule

bind wtc_cache wtc_cache_chk #(.ADDR_W(ADDR_W), .WRD_W(WRD_W), .WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .state_q   (state_q),
  .word_q    (word_q),
  .two_way   (two_way),
  .cpu_ready (cpu_ready),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .fill_en   (fill_en),
  .dwr_en    (dwr_en),
  .touch_en  (touch_en)
);

// File: tb/wtc_cache_tb_top.sv
module wtc_cache_tb_top;

  logic        clk, rst_n, two_way, purge;
  logic        cpu_req, cpu_we, cpu_ready;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        dma_req, dma_we, dma_ready;
  logic [31:0] dma_addr, dma_wdata, dma_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int          errors, checks;
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_log [8];
  logic [31:0] lw_addr, lw_data, salt;

  wtc_cache dut_i (
    .clk(clk), .rst_n(rst_n), .two_way(two_way), .purge(purge),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dma_ready(dma_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // memory model: one ack per request, data = address xor salt
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          wr_cnt++;
          lw_addr = mem_addr;
          lw_data = mem_wdata;
        end else begin
          if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
          mem_rdata = mem_addr ^ salt;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cpu_acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int cyc);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    #1;
    while (mem_req) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic dma_rd(input logic [31:0] a, output logic [31:0] rd);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    dma_req = 1'b1; dma_we = 1'b0; dma_addr = a;
    #1;
    while (!dma_ready) begin
      @(negedge clk); #1;
    end
    rd = dma_rdata;
    @(negedge clk);
    dma_req = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 cpu_ready", {31'd0, cpu_ready}, 32'd0);
    chk("R1 dma_ready", {31'd0, dma_ready}, 32'd0);
  endtask

  task automatic t_fill_hit;
    logic [31:0] d; int c;
    salt = 32'hA5A5_0000;
    cpu_acc(1'b0, 32'h0000_1234, '0, d, c);
    chk("R2 miss data", d, 32'h0000_1234 ^ 32'hA5A5_0000);
    chk("R2 read count", rd_cnt, 4);
    chk("R2 word0 addr", rd_log[0], 32'h0000_1230);
    chk("R2 word1 addr", rd_log[1], 32'h0000_1234);
    chk("R2 word2 addr", rd_log[2], 32'h0000_1238);
    chk("R2 word3 addr", rd_log[3], 32'h0000_123C);
    salt = 32'h5A5A_0000;
    cpu_acc(1'b0, 32'h0000_1238, '0, d, c);
    chk("R3 hit data", d, 32'h0000_1238 ^ 32'hA5A5_0000);
    chk("R3 hit no bus", rd_cnt, 0);
    chk("R3 hit same cycle", c, 0);
  endtask

  task automatic t_bypass;
    logic [31:0] d; int c;
    cpu_acc(1'b0, 32'h2000_2340, '0, d, c);
    chk("R4 one read", rd_cnt, 1);
    chk("R4 address", rd_log[0], 32'h2000_2340);
    chk("R4 data", d, 32'h2000_2340 ^ salt);
    cpu_acc(1'b0, 32'h0000_2340, '0, d, c);
    chk("R4 no allocate", rd_cnt, 4);
    cpu_acc(1'b0, 32'h2000_1234, '0, d, c);
    chk("R4 cached line bypassed", d, 32'h2000_1234 ^ salt);
    chk("R4 cached line one read", rd_cnt, 1);
  endtask

  task automatic t_write;
    logic [31:0] d; int c;
    cpu_acc(1'b1, 32'h0000_1234, 32'hDEAD_BEEF, d, c);
    chk("R5 one write", wr_cnt, 1);
    chk("R5 write addr", lw_addr, 32'h0000_1234);
    chk("R5 write data", lw_data, 32'hDEAD_BEEF);
    cpu_acc(1'b0, 32'h0000_1234, '0, d, c);
    chk("R5 hit updated", d, 32'hDEAD_BEEF);
    chk("R5 hit no bus", rd_cnt, 0);
    cpu_acc(1'b1, 32'h0000_5000, 32'h0BAD_F00D, d, c);
    chk("R6 miss write", wr_cnt, 1);
    cpu_acc(1'b0, 32'h0000_5000, '0, d, c);
    chk("R6 no allocate", rd_cnt, 4);
    chk("R6 data from memory", d, 32'h0000_5000 ^ salt);
  endtask

  task automatic t_plru;
    logic [31:0] d; int c;
    for (int t = 1; t <= 4; t++) begin
      cpu_acc(1'b0, (t << 10) | 32'h50, '0, d, c);
      chk("R7 initial fill", rd_cnt, 4);
    end
    cpu_acc(1'b0, 32'h0000_0450, '0, d, c);
    chk("R7 touch way0", rd_cnt, 0);
    cpu_acc(1'b0, 32'h0000_1450, '0, d, c);
    chk("R7 fifth tag miss", rd_cnt, 4);
    cpu_acc(1'b0, 32'h0000_0C50, '0, d, c);
    chk("R7 way1 kept", rd_cnt, 0);
    cpu_acc(1'b0, 32'h0000_1050, '0, d, c);
    chk("R7 way3 kept", rd_cnt, 0);
    cpu_acc(1'b0, 32'h0000_0450, '0, d, c);
    chk("R7 way0 kept", rd_cnt, 0);
    cpu_acc(1'b0, 32'h0000_0850, '0, d, c);
    chk("R7 way2 evicted", rd_cnt, 4);
  endtask

  task automatic t_purge;
    logic [31:0] d; int c;
    @(negedge clk); purge = 1'b1;
    @(negedge clk); purge = 1'b0;
    cpu_acc(1'b0, 32'h0000_1234, '0, d, c);
    checks++;
    if (c < 60) begin
      errors++;
      $display("FAIL R8 stall actual=%0d expected>=60", c);
    end
    chk("R8 line invalid", rd_cnt, 4);
  endtask

  task automatic t_scratch;
    logic [31:0] d; int c;
    @(negedge clk); two_way = 1'b1;
    cpu_acc(1'b1, 32'hC000_0478, 32'h1111_2222, d, c);
    chk("R9 scratch write no bus", wr_cnt + rd_cnt, 0);
    cpu_acc(1'b1, 32'hC000_0070, 32'h3333_4444, d, c);
    cpu_acc(1'b0, 32'hC000_0478, '0, d, c);
    chk("R9 scratch read", d, 32'h1111_2222);
    chk("R9 scratch read no bus", rd_cnt, 0);
    cpu_acc(1'b0, 32'h0000_0470, '0, d, c);
    cpu_acc(1'b0, 32'h0000_0870, '0, d, c);
    cpu_acc(1'b0, 32'h0000_0C70, '0, d, c);
    chk("R9 third tag miss", rd_cnt, 4);
    cpu_acc(1'b0, 32'h0000_0870, '0, d, c);
    chk("R9 way1 kept", rd_cnt, 0);
    cpu_acc(1'b0, 32'h0000_0470, '0, d, c);
    chk("R9 way0 evicted", rd_cnt, 4);
    cpu_acc(1'b0, 32'hC000_0478, '0, d, c);
    chk("R9 scratch kept hi", d, 32'h1111_2222);
    cpu_acc(1'b0, 32'hC000_0070, '0, d, c);
    chk("R9 scratch kept lo", d, 32'h3333_4444);
  endtask

  task automatic t_dma;
    logic [31:0] d; int c;
    logic [31:0] old_salt;
    old_salt = salt;
    salt = 32'h7777_0000;
    dma_rd(32'h0000_0870, d);
    chk("R10 dma one read", rd_cnt, 1);
    chk("R10 dma data from bus", d, 32'h0000_0870 ^ 32'h7777_0000);
    cpu_acc(1'b0, 32'h0000_0870, '0, d, c);
    chk("R10 cache untouched", d, 32'h0000_0870 ^ old_salt);
    dma_rd(32'h0000_0C80, d);
    cpu_acc(1'b0, 32'h0000_0C80, '0, d, c);
    chk("R10 dma no allocate", rd_cnt, 4);
  endtask

  initial begin
    errors = 0; checks = 0; rd_cnt = 0; wr_cnt = 0;
    salt = '0; lw_addr = '0; lw_data = '0;
    rst_n = 1'b0; two_way = 1'b0; purge = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    dma_req = 1'b0; dma_we = 1'b0; dma_addr = '0; dma_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_fill_hit();
    t_bypass();
    t_write();
    t_plru();
    t_purge();
    t_scratch();
    t_dma();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule